// File: doc/BRIEF.md
# Two-Field Transform-and-Classify Pipeline

This block classifies a packet from two header fields in two registered stages. In the first stage each field is searched in its own ternary transformer table at the same time, over its own input. Each table maps a wide field value onto a short code. In the second stage the two codes, joined into one key, are searched in a third ternary table. That third table holds the classifier, and its result is the decision for the packet. Splitting the work this way keeps every table narrow, and one packet enters and one decision leaves on every clock.

Each table is an array of ternary entries. An entry holds a live bit, a stored value, a per-bit care mask and a result. Software-side logic loads the entries through one write port per table. The packets need no table identifiers, because each table has its own array. A small tag and the valid bit travel with each packet, so the consumer can pair decisions with packets. If any of the three searches finds no entry, the block outputs a default decision and raises a miss flag.

Top module: `pxc_classifier`

## Requirements
- R1: While reset is high, and on the first clock after it, `dec_valid` and `dec_miss` are 0. Packets offered during reset never produce a decision.
- R2: A packet sampled with `pkt_valid`=1 at a rising edge produces `dec_valid`=1 after the second following rising edge. Packets may be offered on every clock, with or without idle gaps. Each packet produces exactly one decision, in order.
- R3: `dec_tag` equals the `pkt_tag` of the packet that the decision belongs to.
- R4: An entry matches a key when its live bit is 1 and, on every bit where its care mask is 1, the key bit equals the stored bit. Key bits where the care mask is 0 are ignored.
- R5: When several entries of one table match, the entry with the lowest index wins.
- R6: Field 1 is searched only in transformer table 1 and field 2 only in transformer table 2. The classifier key is {code1, code2}, with code1 in the upper `X1_W` bits.
- R7: If either transformer or the classifier has no matching entry, `dec_value` = `DEFAULT_DEC` and `dec_miss`=1. Otherwise `dec_miss`=0 and `dec_value` is the result of the first matching classifier entry.
- R8: An entry written with its live bit 0 never matches, whatever its value and mask, including an all-zero mask.
- R9: A table write sampled at a rising edge applies to every search made after that edge. Packets already in flight keep the result they have already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_tag | input | TAG_W | Tag carried with the packet |
| pkt_f1 | input | F1_W | Header field 1 |
| pkt_f2 | input | F2_W | Header field 2 |
| x1_we | input | 1 | Write strobe, transformer table 1 |
| x1_waddr | input | XAW | Entry index, transformer table 1 |
| x1_live | input | 1 | Live bit to write |
| x1_key | input | F1_W | Stored value |
| x1_care | input | F1_W | Care mask (1 = compare the bit) |
| x1_res | input | X1_W | Code produced on a match |
| x2_we | input | 1 | Write strobe, transformer table 2 |
| x2_waddr | input | XAW | Entry index, transformer table 2 |
| x2_live | input | 1 | Live bit to write |
| x2_key | input | F2_W | Stored value |
| x2_care | input | F2_W | Care mask |
| x2_res | input | X2_W | Code produced on a match |
| cl_we | input | 1 | Write strobe, classifier table |
| cl_waddr | input | CAW | Entry index, classifier table |
| cl_live | input | 1 | Live bit to write |
| cl_key | input | CK_W | Stored value over {code1, code2} |
| cl_care | input | CK_W | Care mask |
| cl_res | input | DEC_W | Decision produced on a match |
| dec_valid | output | 1 | Decision present |
| dec_tag | output | TAG_W | Tag of the decided packet |
| dec_value | output | DEC_W | Decision |
| dec_miss | output | 1 | Some table had no match |

## Verification
A corrupted table entry, a wrong priority pick or a swapped key half changes `dec_value` or `dec_miss`. That wrong value shows up exactly two clocks after the first affected packet is sampled, and the bench compares every decision against a value it derives from the entries it wrote. A broken valid or tag pipeline shows at the same cycle as a missing, extra or mislabelled decision. The sweep covers every pair of field values, with idle gaps mixed in. Directed packets cover the priority, disabled-entry and rewrite cases.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  // Index width for a table of n entries (at least one bit)
  function automatic int unsigned addr_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Control bits that ride next to the stage-1 data
  typedef struct packed {
    logic valid;
    logic miss;
  } stage_ctl_t;

endpackage

// File: rtl/pxc_first_hit.sv
module pxc_first_hit #(
  parameter int unsigned N = 8,
  localparam int unsigned AW = pxc_pkg::addr_w(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [AW-1:0] idx
);

  // Scan from the top so the lowest set index is the last one written
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end

endmodule

// File: rtl/pxc_tcam.sv
module pxc_tcam #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned RES_W = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = pxc_pkg::addr_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_live,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [RES_W-1:0] wr_res,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [RES_W-1:0] res
);

  logic [DEPTH-1:0] live_q;
  logic [KEY_W-1:0] ent_key  [DEPTH];
  logic [KEY_W-1:0] ent_care [DEPTH];
  logic [RES_W-1:0] ent_res  [DEPTH];
  logic [DEPTH-1:0] match;
  logic [AW-1:0]    win_idx;

  // Only the live bits need a reset; the entry body is plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (wr_en) begin
      live_q[wr_addr] <= wr_live;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key[wr_addr]  <= wr_key & wr_care;
      ent_care[wr_addr] <= wr_care;
      ent_res[wr_addr]  <= wr_res;
    end
  end

  // One comparator per entry
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    assign match[gi] = live_q[gi] && (((key & ent_care[gi]) ^ ent_key[gi]) == '0);
  end

  pxc_first_hit #(.N(DEPTH)) u_pick (
    .req   (match),
    .found (hit),
    .idx   (win_idx)
  );

  assign res = ent_res[win_idx];

endmodule

// File: rtl/pxc_xform_stage.sv
module pxc_xform_stage #(
  parameter int unsigned F1_W    = 8,
  parameter int unsigned F2_W    = 8,
  parameter int unsigned X1_W    = 3,
  parameter int unsigned X2_W    = 3,
  parameter int unsigned X_DEPTH = 8,
  parameter int unsigned TAG_W   = 4,
  localparam int unsigned XAW = pxc_pkg::addr_w(X_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_valid,
  input  logic [TAG_W-1:0]      pkt_tag,
  input  logic [F1_W-1:0]       pkt_f1,
  input  logic [F2_W-1:0]       pkt_f2,
  input  logic                  x1_we,
  input  logic [XAW-1:0]        x1_waddr,
  input  logic                  x1_live,
  input  logic [F1_W-1:0]       x1_key,
  input  logic [F1_W-1:0]       x1_care,
  input  logic [X1_W-1:0]       x1_res,
  input  logic                  x2_we,
  input  logic [XAW-1:0]        x2_waddr,
  input  logic                  x2_live,
  input  logic [F2_W-1:0]       x2_key,
  input  logic [F2_W-1:0]       x2_care,
  input  logic [X2_W-1:0]       x2_res,
  output pxc_pkg::stage_ctl_t   s1_ctl,
  output logic [TAG_W-1:0]      s1_tag,
  output logic [X1_W-1:0]       s1_code1,
  output logic [X2_W-1:0]       s1_code2
);

  logic            hit1, hit2;
  logic [X1_W-1:0] code1;
  logic [X2_W-1:0] code2;

  // Each field owns its table and its own key bus
  pxc_tcam #(.KEY_W(F1_W), .RES_W(X1_W), .DEPTH(X_DEPTH)) u_tbl1 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (x1_we),
    .wr_addr (x1_waddr),
    .wr_live (x1_live),
    .wr_key  (x1_key),
    .wr_care (x1_care),
    .wr_res  (x1_res),
    .key     (pkt_f1),
    .hit     (hit1),
    .res     (code1)
  );

  pxc_tcam #(.KEY_W(F2_W), .RES_W(X2_W), .DEPTH(X_DEPTH)) u_tbl2 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (x2_we),
    .wr_addr (x2_waddr),
    .wr_live (x2_live),
    .wr_key  (x2_key),
    .wr_care (x2_care),
    .wr_res  (x2_res),
    .key     (pkt_f2),
    .hit     (hit2),
    .res     (code2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_ctl <= '0;
    end else begin
      s1_ctl.valid <= pkt_valid;
      s1_ctl.miss  <= pkt_valid & ~(hit1 & hit2);
    end
  end

  always_ff @(posedge clk) begin
    s1_tag   <= pkt_tag;
    s1_code1 <= code1;
    s1_code2 <= code2;
  end

endmodule

// File: rtl/pxc_classifier.sv
module pxc_classifier #(
  parameter int unsigned F1_W    = 8,
  parameter int unsigned F2_W    = 8,
  parameter int unsigned X1_W    = 3,
  parameter int unsigned X2_W    = 3,
  parameter int unsigned DEC_W   = 6,
  parameter int unsigned X_DEPTH = 8,
  parameter int unsigned C_DEPTH = 16,
  parameter int unsigned TAG_W   = 4,
  parameter logic [DEC_W-1:0] DEFAULT_DEC = '0,
  localparam int unsigned XAW  = pxc_pkg::addr_w(X_DEPTH),
  localparam int unsigned CAW  = pxc_pkg::addr_w(C_DEPTH),
  localparam int unsigned CK_W = X1_W + X2_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic [TAG_W-1:0] pkt_tag,
  input  logic [F1_W-1:0]  pkt_f1,
  input  logic [F2_W-1:0]  pkt_f2,
  input  logic             x1_we,
  input  logic [XAW-1:0]   x1_waddr,
  input  logic             x1_live,
  input  logic [F1_W-1:0]  x1_key,
  input  logic [F1_W-1:0]  x1_care,
  input  logic [X1_W-1:0]  x1_res,
  input  logic             x2_we,
  input  logic [XAW-1:0]   x2_waddr,
  input  logic             x2_live,
  input  logic [F2_W-1:0]  x2_key,
  input  logic [F2_W-1:0]  x2_care,
  input  logic [X2_W-1:0]  x2_res,
  input  logic             cl_we,
  input  logic [CAW-1:0]   cl_waddr,
  input  logic             cl_live,
  input  logic [CK_W-1:0]  cl_key,
  input  logic [CK_W-1:0]  cl_care,
  input  logic [DEC_W-1:0] cl_res,
  output logic             dec_valid,
  output logic [TAG_W-1:0] dec_tag,
  output logic [DEC_W-1:0] dec_value,
  output logic             dec_miss
);

  pxc_pkg::stage_ctl_t s1_ctl;
  logic [TAG_W-1:0]    s1_tag;
  logic [X1_W-1:0]     s1_code1;
  logic [X2_W-1:0]     s1_code2;
  logic                cl_hit;
  logic [DEC_W-1:0]    cl_dec;
  logic                any_miss;

  pxc_xform_stage #(
    .F1_W(F1_W), .F2_W(F2_W), .X1_W(X1_W), .X2_W(X2_W),
    .X_DEPTH(X_DEPTH), .TAG_W(TAG_W)
  ) u_stage1 (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_tag   (pkt_tag),
    .pkt_f1    (pkt_f1),
    .pkt_f2    (pkt_f2),
    .x1_we     (x1_we),
    .x1_waddr  (x1_waddr),
    .x1_live   (x1_live),
    .x1_key    (x1_key),
    .x1_care   (x1_care),
    .x1_res    (x1_res),
    .x2_we     (x2_we),
    .x2_waddr  (x2_waddr),
    .x2_live   (x2_live),
    .x2_key    (x2_key),
    .x2_care   (x2_care),
    .x2_res    (x2_res),
    .s1_ctl    (s1_ctl),
    .s1_tag    (s1_tag),
    .s1_code1  (s1_code1),
    .s1_code2  (s1_code2)
  );

  // Stage two: code1 occupies the upper half of the key
  pxc_tcam #(.KEY_W(CK_W), .RES_W(DEC_W), .DEPTH(C_DEPTH)) u_cls (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cl_we),
    .wr_addr (cl_waddr),
    .wr_live (cl_live),
    .wr_key  (cl_key),
    .wr_care (cl_care),
    .wr_res  (cl_res),
    .key     ({s1_code1, s1_code2}),
    .hit     (cl_hit),
    .res     (cl_dec)
  );

  assign any_miss = s1_ctl.miss | ~cl_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_miss  <= 1'b0;
    end else begin
      dec_valid <= s1_ctl.valid;
      dec_miss  <= s1_ctl.valid & any_miss;
    end
  end

  always_ff @(posedge clk) begin
    dec_tag   <= s1_tag;
    dec_value <= any_miss ? DEFAULT_DEC : cl_dec;
  end

endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned DEC_W = 6,
  parameter logic [DEC_W-1:0] DEFAULT_DEC = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic [TAG_W-1:0] pkt_tag,
  input logic             dec_valid,
  input logic [TAG_W-1:0] dec_tag,
  input logic [DEC_W-1:0] dec_value,
  input logic             dec_miss
);

  logic             v1, v2;
  logic [TAG_W-1:0] t1, t2;

  // Independent two-deep shadow of the packet stream
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= pkt_valid;
      v2 <= v1;
    end
    t1 <= pkt_tag;
    t2 <= t1;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid == v2);

  // R3
  tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> dec_tag == t2);

  // R7
  miss_default_chk: assert property (@(posedge clk) disable iff (rst)
    dec_miss |-> dec_value == DEFAULT_DEC);

  // R7
  idle_no_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_miss);

endmodule

bind pxc_classifier pxc_checker #(
  .TAG_W(TAG_W), .DEC_W(DEC_W), .DEFAULT_DEC(DEFAULT_DEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pkt_valid (pkt_valid),
  .pkt_tag   (pkt_tag),
  .dec_valid (dec_valid),
  .dec_tag   (dec_tag),
  .dec_value (dec_value),
  .dec_miss  (dec_miss)
);

// File: tb/pxc_classifier_tb.sv
module pxc_classifier_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic       pkt_valid = 1'b0;
  logic [3:0] pkt_tag = '0;
  logic [7:0] pkt_f1 = '0, pkt_f2 = '0;
  logic       x1_we = 0, x1_live = 0, x2_we = 0, x2_live = 0, cl_we = 0, cl_live = 0;
  logic [2:0] x1_waddr = '0, x2_waddr = '0;
  logic [3:0] cl_waddr = '0;
  logic [7:0] x1_key = '0, x1_care = '0, x2_key = '0, x2_care = '0;
  logic [2:0] x1_res = '0, x2_res = '0;
  logic [5:0] cl_key = '0, cl_care = '0, cl_res = '0;
  logic       dec_valid, dec_miss;
  logic [3:0] dec_tag;
  logic [5:0] dec_value;

  pxc_classifier u_dut (.*);

  // Bench copy of what has been written
  logic       m1_live [8], m2_live [8], mc_live [16];
  logic [7:0] m1_key [8], m1_care [8], m2_key [8], m2_care [8];
  logic [2:0] m1_res [8], m2_res [8];
  logic [5:0] mc_key [16], mc_care [16], mc_res [16];

  int total = 0, bad = 0;

  // Expected-result pipeline
  logic       e1_v = 0, e2_v = 0, e1_m = 0, e2_m = 0;
  logic [3:0] e1_t = 0, e2_t = 0;
  logic [5:0] e1_d = 0, e2_d = 0;
  string      e1_l = "", e2_l = "";
  logic [3:0] tag_ctr = 0;

  // R4 R5 R8: first live entry whose cared bits agree
  function automatic logic [3:0] look1(input logic [7:0] k);
    logic [3:0] r = 4'b0;
    for (int i = 7; i >= 0; i--)
      if (m1_live[i] && ((k & m1_care[i]) == (m1_key[i] & m1_care[i]))) r = {1'b1, m1_res[i]};
    return r;
  endfunction

  function automatic logic [3:0] look2(input logic [7:0] k);
    logic [3:0] r = 4'b0;
    for (int i = 7; i >= 0; i--)
      if (m2_live[i] && ((k & m2_care[i]) == (m2_key[i] & m2_care[i]))) r = {1'b1, m2_res[i]};
    return r;
  endfunction

  function automatic logic [6:0] lookc(input logic [5:0] k);
    logic [6:0] r = 7'b0;
    for (int i = 15; i >= 0; i--)
      if (mc_live[i] && ((k & mc_care[i]) == (mc_key[i] & mc_care[i]))) r = {1'b1, mc_res[i]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // One clock: check the output due now, then present the next input
  task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b, input string lbl);
    logic [3:0] r1, r2;
    logic [6:0] rc;
    logic       miss;
    string      l;
    @(negedge clk);
    chk("R2 valid", {31'b0, dec_valid}, {31'b0, e2_v});
    if (e2_v) begin
      chk("R3 tag", {28'b0, dec_tag}, {28'b0, e2_t});
      chk({e2_l, " decision"}, {25'b0, dec_miss, dec_value}, {25'b0, e2_m, e2_d});
    end
    e2_v = e1_v; e2_t = e1_t; e2_d = e1_d; e2_m = e1_m; e2_l = e1_l;
    r1 = look1(a);
    r2 = look2(b);
    rc = lookc({r1[2:0], r2[2:0]});  // R6: code1 in the upper half
    miss = !(r1[3] && r2[3] && rc[6]);
    l = (lbl != "") ? lbl : (miss ? "R7" : "R4/R6");
    e1_v = v; e1_t = tag_ctr; e1_m = miss; e1_d = miss ? 6'd0 : rc[5:0]; e1_l = l;
    pkt_valid = v; pkt_tag = tag_ctr; pkt_f1 = a; pkt_f2 = b;
    x1_we = 0; x2_we = 0; cl_we = 0;
    if (v) tag_ctr++;
  endtask

  task automatic wr1(input int i, input logic lv, input logic [7:0] k, input logic [7:0] c, input logic [2:0] r);
    step(0, 0, 0, "");
    x1_we = 1; x1_waddr = i[2:0]; x1_live = lv; x1_key = k; x1_care = c; x1_res = r;
    m1_live[i] = lv; m1_key[i] = k; m1_care[i] = c; m1_res[i] = r;
  endtask

  task automatic wr2(input int i, input logic lv, input logic [7:0] k, input logic [7:0] c, input logic [2:0] r);
    step(0, 0, 0, "");
    x2_we = 1; x2_waddr = i[2:0]; x2_live = lv; x2_key = k; x2_care = c; x2_res = r;
    m2_live[i] = lv; m2_key[i] = k; m2_care[i] = c; m2_res[i] = r;
  endtask

  task automatic wrc(input int i, input logic lv, input logic [5:0] k, input logic [5:0] c, input logic [5:0] r);
    step(0, 0, 0, "");
    cl_we = 1; cl_waddr = i[3:0]; cl_live = lv; cl_key = k; cl_care = c; cl_res = r;
    mc_live[i] = lv; mc_key[i] = k; mc_care[i] = c; mc_res[i] = r;
  endtask

  task automatic run_all();
    for (int i = 0; i < 8; i++) begin m1_live[i] = 0; m2_live[i] = 0; end
    for (int i = 0; i < 16; i++) mc_live[i] = 0;
    // R1: packets offered during reset must leave nothing behind
    pkt_valid = 1; pkt_f1 = 8'h05;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, dec_valid}, 0);
    chk("R1 miss in reset", {31'b0, dec_miss}, 0);
    rst = 0; pkt_valid = 0;
    @(negedge clk);
    chk("R1 valid after reset", {31'b0, dec_valid}, 0);
    chk("R1 miss after reset", {31'b0, dec_miss}, 0);

    // Transformer 1: 0x00-0x0F->1, 0x05->2 (shadowed), 0x1X->3, 0x20-0x3F->4, >=0x80->5
    wr1(0, 1, 8'h00, 8'hF0, 3'd1);
    wr1(1, 1, 8'h05, 8'hFF, 3'd2);
    wr1(2, 1, 8'h10, 8'hF0, 3'd3);
    wr1(3, 1, 8'h20, 8'hE0, 3'd4);
    wr1(4, 1, 8'h80, 8'h80, 3'd5);
    wr1(5, 0, 8'h00, 8'h00, 3'd6);   // R8: dead catch-all
    // Transformer 2: even->0, ..01->1, 0xxxxx11 misses, 1xxxxx11->7
    wr2(0, 1, 8'h00, 8'h01, 3'd0);
    wr2(1, 1, 8'h01, 8'h03, 3'd1);
    wr2(2, 1, 8'h83, 8'h83, 3'd7);
    wr2(3, 0, 8'h00, 8'h00, 3'd5);   // R8: dead catch-all
    // Classifier over {code1, code2}
    wrc(0, 1, {3'd1, 3'd0}, 6'h3F, 6'd10);
    wrc(1, 1, {3'd1, 3'd0}, 6'h38, 6'd11);
    wrc(2, 1, {3'd4, 3'd0}, 6'h20, 6'd12);
    wrc(3, 1, {3'd0, 3'd1}, 6'h07, 6'd13);
    wrc(4, 1, {3'd0, 3'd7}, 6'h07, 6'd14);
    wrc(5, 1, {3'd3, 3'd0}, 6'h3F, 6'd15);  // R6: only the ordered key {3,0} hits

    // Full sweep of both fields with idle gaps
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        if (((a * 256 + b) % 5) == 4) step(0, 0, 0, "");
        step(1, a[7:0], b[7:0], "");
      end

    // R5: 0x05 matches entries 0 and 1; entry 0 wins -> code 1 -> decision 10
    step(1, 8'h05, 8'h00, "R5");
    // R8: kill entry 0; 0x05 now maps to code 2 and 0x00-0x0F otherwise miss
    wr1(0, 0, 8'h00, 8'hF0, 3'd1);
    for (int a = 0; a < 256; a++) step(1, a[7:0], 8'h01, "R8");
    step(1, 8'h05, 8'h00, "R8");
    // R9: restore entry 0, then rewrite classifier entry 0 right before use
    wr1(0, 1, 8'h00, 8'hF0, 3'd1);
    step(1, 8'h03, 8'h00, "R9");
    wrc(0, 1, {3'd1, 3'd0}, 6'h3F, 6'd20);
    step(1, 8'h03, 8'h00, "R9");
    step(1, 8'h03, 8'h02, "R9");
    repeat (3) step(0, 0, 0, "");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout exp=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule